// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The branch address picks one row of signed weights. Each row holds one bias weight and one weight per bit of a global outcome history. The predictor adds the bias to the history weights, counting each weight as positive when its history bit records a taken branch and as negative when it records a not-taken branch. A sum of zero or more means the guess is taken. The guess shifts into the global history at once, so the next request already sees it.

When the branch resolves, the front end hands back the branch address, the true outcome, the history snapshot and the sum returned with the guess. The block trains that row when the guess was wrong, or when the sum was too close to zero to be trusted. On a wrong guess it also rebuilds the global history from the snapshot and the true outcome.

A request is answered one cycle later through registered outputs. Each answer carries the guess, the sum and the history that produced it.

Top module: `pcpt_predictor`

## Requirements
- R1: The row is taken from address bits [PC_LSB+IDX_W-1:PC_LSB], which are bits [5:2] with the defaults (16 rows). The same bits select the row for requests and for updates.
- R2: The sum is the bias weight plus, for each i from 1 to HIST_LEN, the weight wi times xi. xi is +1 when history bit i-1 is 1 (taken) and -1 when it is 0. History bit 0 is the most recent outcome.
- R3: A request in cycle k makes pred_valid_o high in cycle k+1, with pred_sum_o holding the sum, pred_taken_o = 1 exactly when the sum is at least 0, and pred_hist_o holding the history used.
- R4: Each request shifts the global history left by one bit and puts the guessed outcome into bit 0.
- R5: An update trains the row only when it is a mispredict, meaning (upd_sum_i >= 0) differs from upd_taken_i, or when |upd_sum_i| <= THETA (29 by default). Otherwise the row is left unchanged.
- R6: Training moves the bias weight by +1 on a taken outcome and by -1 on a not-taken outcome. It moves each wi by +1 when bit i-1 of upd_hist_i equals the outcome, and by -1 when it does not.
- R7: Weights are signed 8-bit values that stay at +127 when stepped up and at -128 when stepped down.
- R8: A mispredict sets the global history to {upd_hist_i[HIST_LEN-2:0], upd_taken_i}. This repair takes priority over the shift from a request in the same cycle.
- R9: After reset all weights and the history are zero, so the first request returns sum 0, taken and history 0.
- R10: When a request and an update hit the same row in the same cycle, the request sees the weights as they were before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pred_valid_i | input | 1 | Prediction request |
| pred_pc_i | input | PC_W | Branch address for the request |
| pred_valid_o | output | 1 | Answer valid, one cycle after the request |
| pred_taken_o | output | 1 | Guessed direction, 1 = taken |
| pred_sum_o | output | SUM_W | Signed weighted sum |
| pred_hist_o | output | HIST_LEN | History snapshot used for the guess |
| upd_valid_i | input | 1 | Resolution update |
| upd_pc_i | input | PC_W | Branch address being resolved |
| upd_taken_i | input | 1 | True outcome |
| upd_hist_i | input | HIST_LEN | History snapshot returned with the guess |
| upd_sum_i | input | SUM_W | Signed sum returned with the guess |

## Verification
The speculative history shift and the mispredict repair can fall in the same cycle. The bench provokes this by raising a request and a mispredicting update on the same clock edge. It judges the result from the history the next request reports, which must equal the repaired value with no trace of the speculative bit. A request and a training update to the same row in one cycle are also driven together, and the returned sum must match the weights from before the update.

// File: rtl/pcpt_pkg.sv
package pcpt_pkg;
    parameter int WGT_W = 8;

    typedef logic signed [WGT_W-1:0] wgt_t;

    localparam wgt_t WGT_MAX = wgt_t'({1'b0, {(WGT_W-1){1'b1}}});
    localparam wgt_t WGT_MIN = wgt_t'({1'b1, {(WGT_W-1){1'b0}}});

    function automatic wgt_t sat_step(input wgt_t w, input logic up);
        wgt_t r;
        if (up) r = (w == WGT_MAX) ? w : wgt_t'(w + wgt_t'(1));
        else    r = (w == WGT_MIN) ? w : wgt_t'(w - wgt_t'(1));
        return r;
    endfunction
endpackage

// File: rtl/pcpt_weights.sv
module pcpt_weights
    import pcpt_pkg::*;
#(
    parameter int ROWS     = 16,
    parameter int HIST_LEN = 8,
    localparam int IDX_W   = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output wgt_t [HIST_LEN:0]    rd_row,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_taken,
    input  logic [HIST_LEN-1:0]  wr_hist
);
    typedef struct packed {
        wgt_t [ROWS-1:0][HIST_LEN:0] w;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.w[wr_idx][0] = sat_step(st_q.w[wr_idx][0], wr_taken);
            for (int j = 1; j <= HIST_LEN; j++) begin
                st_d.w[wr_idx][j] = sat_step(st_q.w[wr_idx][j], wr_hist[j-1] == wr_taken);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_row = st_q.w[rd_idx];

    // R5
    no_train_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    // R7
    bias_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.w[wr_idx][0] == WGT_MAX) |=> st_q.w[$past(wr_idx)][0] == WGT_MAX);

    // R7
    bias_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.w[wr_idx][0] == WGT_MIN) |=> st_q.w[$past(wr_idx)][0] == WGT_MIN);
endmodule

// File: rtl/pcpt_dot.sv
module pcpt_dot
    import pcpt_pkg::*;
#(
    parameter int HIST_LEN = 8,
    parameter int SUM_W    = 12
) (
    input  wgt_t [HIST_LEN:0]         row,
    input  logic [HIST_LEN-1:0]       hist,
    output logic signed [SUM_W-1:0]   sum
);
    function automatic logic signed [SUM_W-1:0] widen(input wgt_t w);
        return {{(SUM_W-WGT_W){w[WGT_W-1]}}, w};
    endfunction

    always_comb begin
        sum = widen(row[0]);
        for (int i = 1; i <= HIST_LEN; i++) begin
            if (hist[i-1]) sum = sum + widen(row[i]);
            else           sum = sum - widen(row[i]);
        end
    end
endmodule

// File: rtl/pcpt_ghr.sv
module pcpt_ghr #(
    parameter int HIST_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spec_en,
    input  logic                 spec_bit,
    input  logic                 fix_en,
    input  logic [HIST_LEN-1:0]  fix_hist,
    input  logic                 fix_bit,
    output logic [HIST_LEN-1:0]  hist
);
    typedef struct packed {
        logic [HIST_LEN-1:0] bits;
    } ghr_t;

    ghr_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (fix_en)       g_d.bits = {fix_hist[HIST_LEN-2:0], fix_bit};
        else if (spec_en) g_d.bits = {g_q.bits[HIST_LEN-2:0], spec_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hist = g_q.bits;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_en && !fix_en) |=> $stable(g_q));
endmodule

// File: rtl/pcpt_predictor.sv
module pcpt_predictor
    import pcpt_pkg::*;
#(
    parameter int ROWS     = 16,
    parameter int HIST_LEN = 8,
    parameter int PC_W     = 16,
    parameter int PC_LSB   = 2,
    parameter int THETA    = 29,
    localparam int IDX_W   = $clog2(ROWS),
    localparam int SUM_W   = $clog2((HIST_LEN+1)*(2**(WGT_W-1))) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pred_valid_i,
    input  logic [PC_W-1:0]             pred_pc_i,
    output logic                        pred_valid_o,
    output logic                        pred_taken_o,
    output logic signed [SUM_W-1:0]     pred_sum_o,
    output logic [HIST_LEN-1:0]         pred_hist_o,
    input  logic                        upd_valid_i,
    input  logic [PC_W-1:0]             upd_pc_i,
    input  logic                        upd_taken_i,
    input  logic [HIST_LEN-1:0]         upd_hist_i,
    input  logic signed [SUM_W-1:0]     upd_sum_i
);
    typedef struct packed {
        logic                valid;
        logic                taken;
        logic [SUM_W-1:0]    sum;
        logic [HIST_LEN-1:0] hist;
    } out_t;

    out_t o_d, o_q;

    logic [IDX_W-1:0]         rd_idx, wr_idx;
    wgt_t [HIST_LEN:0]        row;
    logic signed [SUM_W-1:0]  sum_now;
    logic [HIST_LEN-1:0]      ghr_q;
    logic                     guess;
    logic                     upd_guess, mispred, train;
    logic [SUM_W:0]           mag;
    logic                     unused_pc;

    assign rd_idx    = pred_pc_i[PC_LSB +: IDX_W];
    assign wr_idx    = upd_pc_i[PC_LSB +: IDX_W];
    assign unused_pc = ^{pred_pc_i, upd_pc_i};

    assign upd_guess = !upd_sum_i[SUM_W-1];
    assign mispred   = upd_valid_i && (upd_guess != upd_taken_i);
    assign mag       = upd_sum_i[SUM_W-1] ? (SUM_W+1)'(-$signed({upd_sum_i[SUM_W-1], upd_sum_i}))
                                          : (SUM_W+1)'({1'b0, upd_sum_i});
    assign train     = upd_valid_i && (mispred || (mag <= (SUM_W+1)'(THETA)));

    pcpt_weights #(.ROWS(ROWS), .HIST_LEN(HIST_LEN)) i_weights (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_row   (row),
        .wr_en    (train),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken_i),
        .wr_hist  (upd_hist_i)
    );

    pcpt_dot #(.HIST_LEN(HIST_LEN), .SUM_W(SUM_W)) i_dot (
        .row  (row),
        .hist (ghr_q),
        .sum  (sum_now)
    );

    assign guess = !sum_now[SUM_W-1];

    pcpt_ghr #(.HIST_LEN(HIST_LEN)) i_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (pred_valid_i),
        .spec_bit (guess),
        .fix_en   (mispred),
        .fix_hist (upd_hist_i),
        .fix_bit  (upd_taken_i),
        .hist     (ghr_q)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = pred_valid_i;
        if (pred_valid_i) begin
            o_d.taken = guess;
            o_d.sum   = sum_now;
            o_d.hist  = ghr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pred_valid_o = o_q.valid;
    assign pred_taken_o = o_q.taken;
    assign pred_sum_o   = o_q.sum;
    assign pred_hist_o  = o_q.hist;

    // R4
    spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_i && !mispred) |=> ghr_q == {$past(ghr_q[HIST_LEN-2:0]), pred_taken_o});

    // R8
    repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispred |=> ghr_q == {$past(upd_hist_i[HIST_LEN-2:0]), $past(upd_taken_i)});

    // R3
    snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_i |=> (pred_valid_o && pred_hist_o == $past(ghr_q)));
endmodule

// File: tb/test_pcpt_predictor.sv
`timescale 1ns/1ps
module test_pcpt_predictor;
    localparam int ROWS = 16, H = 8, PC_W = 16, PC_LSB = 2, THETA = 29, SUM_W = 12;
    localparam int NV = 12;
    localparam logic [PC_W-1:0] VPC [NV] = '{16'h0040, 16'h0044, 16'h0040, 16'h0048,
                                             16'h0040, 16'h0044, 16'h0104, 16'h0040,
                                             16'h0048, 16'h007C, 16'h0040, 16'h0044};
    localparam bit VOUT [NV] = '{1, 0, 1, 1, 0, 0, 1, 1, 0, 1, 1, 0};

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic pred_valid_i = 0, upd_valid_i = 0, upd_taken_i = 0;
    logic [PC_W-1:0] pred_pc_i = '0, upd_pc_i = '0;
    logic [H-1:0] upd_hist_i = '0;
    logic signed [SUM_W-1:0] upd_sum_i = '0;
    logic pred_valid_o, pred_taken_o;
    logic signed [SUM_W-1:0] pred_sum_o;
    logic [H-1:0] pred_hist_o;

    pcpt_predictor i_pcpt_predictor (
        .clk(clk), .rst_n(rst_n),
        .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
        .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
        .pred_sum_o(pred_sum_o), .pred_hist_o(pred_hist_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
        .upd_hist_i(upd_hist_i), .upd_sum_i(upd_sum_i)
    );

    int errors = 0, checks = 0;
    bit done = 0;
    int mw [ROWS][H+1];
    logic [H-1:0] mghr;
    int exp_sum;
    logic [H-1:0] exp_hist;

    task automatic chk(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int m_idx(input logic [PC_W-1:0] pc);
        return int'(pc[PC_LSB +: 4]);
    endfunction

    function automatic int m_sum(input int r, input logic [H-1:0] h);
        int s = mw[r][0];
        for (int i = 1; i <= H; i++) s += h[i-1] ? mw[r][i] : -mw[r][i];
        return s;
    endfunction

    function automatic int m_sat(input int w, input bit up);
        if (up) return (w >= 127) ? 127 : w + 1;
        return (w <= -128) ? -128 : w - 1;
    endfunction

    // model of a request: records expected answer and shifts history
    task automatic m_pred(input logic [PC_W-1:0] pc);
        exp_sum  = m_sum(m_idx(pc), mghr);
        exp_hist = mghr;
        mghr     = {mghr[H-2:0], exp_sum >= 0};
    endtask

    task automatic m_upd(input logic [PC_W-1:0] pc, input bit t, input logic [H-1:0] h, input int s);
        int r = m_idx(pc);
        bit mis = (s >= 0) != t;
        int mg = (s < 0) ? -s : s;
        if (mis || mg <= THETA) begin
            mw[r][0] = m_sat(mw[r][0], t);
            for (int i = 1; i <= H; i++) mw[r][i] = m_sat(mw[r][i], h[i-1] == t);
        end
        if (mis) mghr = {h[H-2:0], t};
    endtask

    task automatic check_answer(input string req);
        chk(req, pred_valid_o === 1'b1, int'(pred_valid_o), 1);
        chk(req, int'(pred_sum_o) == exp_sum, int'(pred_sum_o), exp_sum);
        chk(req, pred_taken_o === (exp_sum >= 0), int'(pred_taken_o), int'(exp_sum >= 0));
        chk(req, pred_hist_o === exp_hist, int'(pred_hist_o), int'(exp_hist));
    endtask

    task automatic do_pred(input logic [PC_W-1:0] pc, input string req);
        @(negedge clk);
        pred_valid_i = 1; pred_pc_i = pc;
        m_pred(pc);
        @(negedge clk);
        pred_valid_i = 0;
        check_answer(req);
    endtask

    task automatic do_upd(input logic [PC_W-1:0] pc, input bit t, input logic [H-1:0] h, input int s);
        @(negedge clk);
        upd_valid_i = 1; upd_pc_i = pc; upd_taken_i = t; upd_hist_i = h;
        upd_sum_i = SUM_W'(s);
        m_upd(pc, t, h, s);
        @(negedge clk);
        upd_valid_i = 0;
    endtask

    task automatic do_both(input logic [PC_W-1:0] ppc, input logic [PC_W-1:0] upc,
                           input bit t, input logic [H-1:0] h, input int s, input string req);
        @(negedge clk);
        pred_valid_i = 1; pred_pc_i = ppc;
        upd_valid_i = 1; upd_pc_i = upc; upd_taken_i = t; upd_hist_i = h;
        upd_sum_i = SUM_W'(s);
        m_pred(ppc);
        m_upd(upc, t, h, s);
        @(negedge clk);
        pred_valid_i = 0; upd_valid_i = 0;
        check_answer(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s_before;
        logic [H-1:0] hs;
        for (int r = 0; r < ROWS; r++) for (int i = 0; i <= H; i++) mw[r][i] = 0;
        mghr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9: reset state
        chk("R9 valid low", pred_valid_o === 1'b0, int'(pred_valid_o), 0);
        do_pred(16'h0000, "R9 first prediction");

        // R1 R2 R3 R4 R5 R6: vector walk
        for (int v = 0; v < NV; v++) begin
            do_pred(VPC[v], "R2 R3 R4 vector");
            do_upd(VPC[v], VOUT[v], pred_hist_o, int'(pred_sum_o));
        end
        // R1: address bits above the index alias to the same row
        do_pred(16'h0440, "R1 alias row");

        // R5: confident correct update leaves the row alone
        do_pred(16'h0050, "R5 before");
        s_before = int'(pred_sum_o);
        do_upd(16'h0050, 1'b1, 8'h00, THETA + 1);
        do_pred(16'h0050, "R5 above threshold");
        hs = pred_hist_o;
        do_upd(16'h0050, 1'b1, 8'h00, THETA);
        do_pred(16'h0050, "R5 at threshold");
        chk("R6 trained row differs", int'(pred_sum_o) != s_before || hs != pred_hist_o,
            int'(pred_sum_o), s_before);

        // R7: saturation high then low on row 5
        for (int k = 0; k < 140; k++) do_upd(16'h0014, 1'b1, 8'hFF, 0);
        do_pred(16'h0014, "R7 saturate high");
        for (int k = 0; k < 300; k++) do_upd(16'h0014, 1'b0, 8'hFF, -1);
        do_pred(16'h0014, "R7 saturate low");

        // R8: mispredict repair
        do_upd(16'h0020, 1'b0, 8'hA5, 5);
        do_pred(16'h0024, "R8 repaired history 0x4A");
        chk("R8 repaired value", exp_hist == 8'h4A, int'(exp_hist), 8'h4A);

        // R8: repair wins over same-cycle speculative shift
        do_both(16'h0028, 16'h0030, 1'b1, 8'h3C, -7, "R8 same-cycle request");
        do_pred(16'h0028, "R8 repair priority");
        chk("R8 priority value", pred_hist_o === 8'h79, int'(pred_hist_o), 8'h79);

        // R10: same row read before write
        do_both(16'h0034, 16'h0034, 1'b1, 8'h0F, 3, "R10 read before write");
        do_pred(16'h0034, "R10 after write");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule